// File: doc/BRIEF.md
# DRAM Periodic Read Injector

This block sits between the pending request queue and a DRAM command scheduler. The physical layer needs two read commands accepted on consecutive cycles at least once per maintenance interval. The block forwards user commands unchanged. It watches every read the scheduler accepts. If no back-to-back pair has been accepted for too long, it holds user traffic and issues its own activate (when needed) and two reads.

The target of an injected pair is the address of the request waiting at the head of the queue. When nothing is waiting, the target is the address of the last command the scheduler accepted. The block compares the target row with the scheduler's table of open rows and issues an activate first if that row is not open. Every injected command carries a marker bit. On the return path, beats with the marker set are dropped, and the user sees only its own data, in its original order.

The control is a four-state machine:
- `S_PASS` forwards user commands. Its transition `DUE_HIT` leads to `S_RD1` and its transition `DUE_MISS` leads to `S_ACT`; both are taken when the interval has run out.
- `S_ACT` issues the activate. Its transition `ACT_DONE` leads to `S_RD1`.
- `S_RD1` issues the first injected read. Its transition `RD1_DONE` leads to `S_RD2`.
- `S_RD2` issues the second injected read. Its transition `RD2_DONE` returns to `S_PASS`.

Top module: `prd_inject_top`

## Requirements
- R1: While reset is held, `cmd_valid` and `usr_rd_valid` are low. After reset the interval timer starts from zero and the last-address register holds address 0, meaning bank 0, row 0, column 0.
- R2: A read is counted when `cmd_valid`, `cmd_ready` and `cmd_op`=0 (read) are all high in the same cycle. Two such reads in consecutive cycles form a qualifying pair, whether the user or the block issued them. A qualifying pair restarts the interval. If user pairs keep arriving inside every interval, nothing is injected.
- R3: The block starts an injection in the cycle the timer reaches `INTERVAL_CYCLES-4` cycles without a qualifying pair. Single reads that are not back-to-back do not prevent it. While the scheduler is always ready, qualifying pairs complete at most `INTERVAL_CYCLES` cycles apart.
- R4: If `usr_valid` is high in the cycle the injection is decided, the injected commands use `usr_addr`, which is the head of the queue.
- R5: If `usr_valid` is low in that cycle, the injected commands use the address of the last command the scheduler accepted, or address 0 if none has been accepted since reset.
- R6: An activate (`cmd_op`=2) to the target address comes before the two reads unless the target bank is marked open in `bank_open` and its entry in `open_rows` equals the target row. The address is packed as {bank[2], row[14], column[10]}, with the bank in the most significant bits, and bank b's row is `open_rows[b*14 +: 14]`.
- R7: From the decision cycle until the second injected read is accepted, `usr_ready` is low and no user command reaches the scheduler.
- R8: Injected activates and reads carry `cmd_tag`=1, and all forwarded user commands carry `cmd_tag`=0. User writes use `cmd_op`=1.
- R9: A return beat with `ret_tag`=1 never raises `usr_rd_valid`. A beat with `ret_tag`=0 appears on `usr_rd_valid` and `usr_rd_data` one cycle later. The order of untagged beats is kept.
- R10: If the two injected reads are not accepted in consecutive cycles, the interval stays expired and the block injects again, repeating until a back-to-back pair is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_valid | input | 1 | Queue head request present |
| usr_ready | output | 1 | Queue head taken this cycle |
| usr_is_read | input | 1 | Queue head is a read (else write) |
| usr_addr | input | 26 | Queue head address {bank,row,col} |
| bank_open | input | 4 | Per-bank open-row flag from scheduler |
| open_rows | input | 56 | Open row per bank, 14 bits each |
| cmd_valid | output | 1 | Command to scheduler valid |
| cmd_ready | input | 1 | Scheduler accepts command |
| cmd_op | output | 2 | 0 read, 1 write, 2 activate |
| cmd_addr | output | 26 | Command address |
| cmd_tag | output | 1 | Injected-command marker |
| ret_valid | input | 1 | Read data beat from scheduler |
| ret_tag | input | 1 | Marker returned with the beat |
| ret_data | input | DATA_W | Returned data |
| usr_rd_valid | output | 1 | Read data to user valid |
| usr_rd_data | output | DATA_W | Read data to user |

## Verification
The injector is driven with several traffic patterns, and each one separates a different part of its behaviour:
- No traffic, with every bank closed: shows the default address and the activate, and lets the spacing between repeated pairs be measured against the interval.
- No traffic, with the target row already open: shows that the activate is skipped.
- A lone write followed by silence: shows that an idle injection uses the remembered address.
- A continuous stream of writes whose address advances on each acceptance: shows that the target comes from the queue head rather than from history, and that user commands are blocked during the injection.
- Regular user read pairs, and single reads spaced apart: show that only back-to-back reads satisfy the timer.
- A one-cycle scheduler stall between the injected reads: shows the retry.
- A mixed sequence of marked and unmarked return beats: shows filtering without reordering.

// File: rtl/prd_pkg.sv
package prd_pkg;
    localparam int BANK_W    = 2;
    localparam int ROW_W     = 14;
    localparam int COL_W     = 10;
    localparam int ADDR_W    = BANK_W + ROW_W + COL_W;
    localparam int NUM_BANKS = 1 << BANK_W;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ACT   = 2'd2
    } cmd_op_e;

    typedef enum logic [1:0] {
        S_PASS = 2'd0,
        S_ACT  = 2'd1,
        S_RD1  = 2'd2,
        S_RD2  = 2'd3
    } inj_state_e;
endpackage

// File: rtl/prd_window_timer.sv
module prd_window_timer #(
    parameter int INTERVAL_CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_acc,
    output logic due
);
    localparam int LIMIT = INTERVAL_CYCLES - 4;
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             prev_q;
    logic             pair;

    assign pair = rd_acc && prev_q;
    assign due  = (cnt_q == CNT_W'(LIMIT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= rd_acc;
            if (pair)
                cnt_q <= '0;
            else if (!due)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: a back-to-back pair clears the expired condition
    p_pair_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && $past(rd_acc)) |=> !due);

    // R10: expiry holds until a pair is seen
    p_due_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (due && !(rd_acc && prev_q)) |=> due);
endmodule

// File: rtl/prd_target_sel.sv
module prd_target_sel
    import prd_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc,
    input  logic [ADDR_W-1:0]         acc_addr,
    input  logic                      head_valid,
    input  logic [ADDR_W-1:0]         head_addr,
    input  logic [NUM_BANKS-1:0]      bank_open,
    input  logic [NUM_BANKS*ROW_W-1:0] open_rows,
    output logic [ADDR_W-1:0]         tgt_addr,
    output logic                      tgt_hit
);
    logic [ADDR_W-1:0]    last_q;
    logic [NUM_BANKS-1:0] hit_vec;
    logic [BANK_W-1:0]    tgt_bank;
    logic [ROW_W-1:0]     tgt_row;

    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= '0;
        else if (acc)
            last_q <= acc_addr;
    end

    assign tgt_addr = head_valid ? head_addr : last_q;
    assign tgt_bank = tgt_addr[ADDR_W-1 -: BANK_W];
    assign tgt_row  = tgt_addr[COL_W +: ROW_W];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_hit
        assign hit_vec[b] = bank_open[b] && (open_rows[b*ROW_W +: ROW_W] == tgt_row);
    end

    assign tgt_hit = hit_vec[tgt_bank];

    // R5: history register follows every accepted command
    p_last_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (last_q == $past(acc_addr)));
endmodule

// File: rtl/prd_ret_filter.sv
module prd_ret_filter #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic              ret_tag,
    input  logic [DATA_W-1:0] ret_data,
    output logic              usr_rd_valid,
    output logic [DATA_W-1:0] usr_rd_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usr_rd_valid <= 1'b0;
            usr_rd_data  <= '0;
        end else begin
            usr_rd_valid <= ret_valid && !ret_tag;
            if (ret_valid && !ret_tag)
                usr_rd_data <= ret_data;
        end
    end

    // R9: marked beats are swallowed
    p_tag_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_tag) |=> !usr_rd_valid);

    // R9: unmarked beats pass one cycle later with their data
    p_untagged_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_tag) |=> (usr_rd_valid && usr_rd_data == $past(ret_data)));
endmodule

// File: rtl/prd_inject_top.sv
module prd_inject_top
    import prd_pkg::*;
#(
    parameter int INTERVAL_CYCLES = 250,
    parameter int DATA_W          = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       usr_valid,
    output logic                       usr_ready,
    input  logic                       usr_is_read,
    input  logic [ADDR_W-1:0]          usr_addr,
    input  logic [NUM_BANKS-1:0]       bank_open,
    input  logic [NUM_BANKS*ROW_W-1:0] open_rows,
    output logic                       cmd_valid,
    input  logic                       cmd_ready,
    output logic [1:0]                 cmd_op,
    output logic [ADDR_W-1:0]          cmd_addr,
    output logic                       cmd_tag,
    input  logic                       ret_valid,
    input  logic                       ret_tag,
    input  logic [DATA_W-1:0]          ret_data,
    output logic                       usr_rd_valid,
    output logic [DATA_W-1:0]          usr_rd_data
);
    inj_state_e        state_q, state_d;
    logic [ADDR_W-1:0] tgt_q;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_hit;
    logic              due;
    logic              cmd_acc;
    logic              rd_acc;

    assign cmd_acc = cmd_valid && cmd_ready;
    assign rd_acc  = cmd_acc && (cmd_op == OP_READ);

    prd_window_timer #(.INTERVAL_CYCLES(INTERVAL_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_acc (rd_acc),
        .due    (due)
    );

    prd_target_sel u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (cmd_acc),
        .acc_addr   (cmd_addr),
        .head_valid (usr_valid),
        .head_addr  (usr_addr),
        .bank_open  (bank_open),
        .open_rows  (open_rows),
        .tgt_addr   (sel_addr),
        .tgt_hit    (sel_hit)
    );

    prd_ret_filter #(.DATA_W(DATA_W)) u_filt (
        .clk          (clk),
        .rst_n        (rst_n),
        .ret_valid    (ret_valid),
        .ret_tag      (ret_tag),
        .ret_data     (ret_data),
        .usr_rd_valid (usr_rd_valid),
        .usr_rd_data  (usr_rd_data)
    );

    // state register and captured target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_PASS;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_PASS && due)
                tgt_q <= sel_addr;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_PASS: if (due) state_d = sel_hit ? S_RD1 : S_ACT;   // DUE_HIT / DUE_MISS
            S_ACT:  if (cmd_ready) state_d = S_RD1;               // ACT_DONE
            S_RD1:  if (cmd_ready) state_d = S_RD2;               // RD1_DONE
            S_RD2:  if (cmd_ready) state_d = S_PASS;              // RD2_DONE
        endcase
    end

    // outputs
    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_READ;
        cmd_addr  = tgt_q;
        cmd_tag   = 1'b1;
        usr_ready = 1'b0;
        unique case (state_q)
            S_PASS: begin
                if (!due) begin
                    cmd_valid = usr_valid;
                    cmd_op    = usr_is_read ? OP_READ : OP_WRITE;
                    cmd_addr  = usr_addr;
                    cmd_tag   = 1'b0;
                    usr_ready = cmd_ready;
                end
            end
            S_ACT: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_ACT;
            end
            S_RD1, S_RD2: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_READ;
            end
        endcase
    end

    // R7: user side is held off whenever an injection is in flight
    p_block_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_PASS) |-> !usr_ready);

    // R6: an accepted activate is followed by an injected read
    p_act_then_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACT && cmd_ready) |=> (cmd_valid && cmd_op == OP_READ && cmd_tag));

    // R4: both injected reads target the same address
    p_pair_same_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD1 && cmd_ready) |=> (cmd_addr == $past(cmd_addr)));

    // R8: commands accepted from the user port carry no marker
    p_user_untagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_valid && usr_ready) |-> (cmd_acc && !cmd_tag));
endmodule

// File: tb/sim_prd_inject_top.sv
`timescale 1ns/1ps
module sim_prd_inject_top;
    import prd_pkg::*;

    localparam int IV  = 40;
    localparam int DW  = 16;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       usr_valid = 1'b0;
    logic                       usr_ready;
    logic                       usr_is_read = 1'b0;
    logic [ADDR_W-1:0]          usr_addr = '0;
    logic [NUM_BANKS-1:0]       bank_open = '0;
    logic [NUM_BANKS*ROW_W-1:0] open_rows = '0;
    logic                       cmd_valid;
    logic                       cmd_ready = 1'b1;
    logic [1:0]                 cmd_op;
    logic [ADDR_W-1:0]          cmd_addr;
    logic                       cmd_tag;
    logic                       ret_valid = 1'b0;
    logic                       ret_tag = 1'b0;
    logic [DW-1:0]              ret_data = '0;
    logic                       usr_rd_valid;
    logic [DW-1:0]              usr_rd_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [1:0]        lg_op   [0:511];
    logic [ADDR_W-1:0] lg_addr [0:511];
    logic              lg_tag  [0:511];
    int                lg_cyc  [0:511];
    int                lg_n = 0;
    bit                stall_arm = 1'b0;
    bit                stall_pend = 1'b0;

    prd_inject_top #(.INTERVAL_CYCLES(IV), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .usr_valid(usr_valid), .usr_ready(usr_ready), .usr_is_read(usr_is_read), .usr_addr(usr_addr),
        .bank_open(bank_open), .open_rows(open_rows),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_tag(cmd_tag),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_data(ret_data),
        .usr_rd_valid(usr_rd_valid), .usr_rd_data(usr_rd_data)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // scheduler model: accept log and ready driver, both at the falling edge
    always @(negedge clk) begin
        if (stall_pend) begin
            cmd_ready  = 1'b0;
            stall_pend = 1'b0;
        end else begin
            cmd_ready = 1'b1;
        end
        if (rst_n && cmd_valid && cmd_ready) begin
            if (lg_n < 512) begin
                lg_op[lg_n]   = cmd_op;
                lg_addr[lg_n] = cmd_addr;
                lg_tag[lg_n]  = cmd_tag;
                lg_cyc[lg_n]  = cyc;
                lg_n++;
            end
            if (stall_arm && cmd_tag && cmd_op == 2'd0) begin
                stall_pend = 1'b1;
                stall_arm  = 1'b0;
            end
        end
    end

    function automatic logic [ADDR_W-1:0] mk(int b, int r, int c);
        return {BANK_W'(b), ROW_W'(r), COL_W'(c)};
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int first_tagged();
        for (int i = 0; i < lg_n; i++) if (lg_tag[i]) return i;
        return -1;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        usr_valid = 1'b0;
        ret_valid = 1'b0;
        stall_arm = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd_valid == 1'b0, "R1", "cmd_valid in reset", cmd_valid, 0);
        chk(usr_rd_valid == 1'b0, "R1", "usr_rd_valid in reset", usr_rd_valid, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        lg_n = 0;
    endtask

    task automatic t_idle_closed();
        int k;
        int last_pair;
        int gaps;
        bank_open = '0;
        do_reset();
        repeat (140) @(posedge clk);
        k = first_tagged();
        chk(k == 0, "R5", "first logged command is injected", k, 0);
        if (k >= 0 && k + 2 < lg_n) begin
            chk(lg_op[k] == 2'd2, "R6", "activate first on closed bank", lg_op[k], 2);
            chk(lg_addr[k] == '0, "R5", "default target address", lg_addr[k], 0);
            chk(lg_op[k+1] == 2'd0 && lg_op[k+2] == 2'd0, "R8", "two reads follow", lg_op[k+2], 0);
            chk(lg_tag[k+1] && lg_tag[k+2], "R8", "injected reads tagged", lg_tag[k+2], 1);
            chk(lg_cyc[k+2] - lg_cyc[k+1] == 1, "R3", "reads back-to-back", lg_cyc[k+2] - lg_cyc[k+1], 1);
        end
        last_pair = -1;
        gaps = 0;
        for (int i = 1; i < lg_n; i++) begin
            if (lg_op[i] == 2'd0 && lg_op[i-1] == 2'd0 && lg_cyc[i] - lg_cyc[i-1] == 1) begin
                if (last_pair >= 0) begin
                    chk(lg_cyc[i] - last_pair <= IV && lg_cyc[i] - last_pair >= IV - 4,
                        "R3", "pair spacing", lg_cyc[i] - last_pair, IV);
                    gaps++;
                end
                last_pair = lg_cyc[i];
            end
        end
        chk(gaps >= 2, "R3", "repeated injections seen", gaps, 2);
    endtask

    task automatic t_idle_open();
        int k;
        bank_open = 4'b0001;
        open_rows = '0;
        do_reset();
        repeat (50) @(posedge clk);
        k = first_tagged();
        chk(k >= 0 && lg_op[k] == 2'd0, "R6", "no activate when row open", (k >= 0) ? lg_op[k] : 3, 0);
        if (k >= 0 && k + 1 < lg_n)
            chk(lg_op[k+1] == 2'd0 && lg_cyc[k+1] - lg_cyc[k] == 1, "R6", "second read follows",
                lg_cyc[k+1] - lg_cyc[k], 1);
        bank_open = '0;
    endtask

    task automatic t_last_addr();
        int k;
        logic [ADDR_W-1:0] b_addr;
        b_addr = mk(2, 7, 5);
        bank_open = '0;
        do_reset();
        usr_valid = 1'b1; usr_is_read = 1'b0; usr_addr = b_addr;
        @(posedge clk); #1;
        usr_valid = 1'b0;
        repeat (50) @(posedge clk);
        chk(lg_n > 0 && lg_tag[0] == 1'b0 && lg_op[0] == 2'd1, "R8", "user write untagged", lg_tag[0], 0);
        k = first_tagged();
        chk(k >= 0 && lg_op[k] == 2'd2 && lg_addr[k] == b_addr, "R5", "activate to last address",
            (k >= 0) ? lg_addr[k] : 0, b_addr);
        if (k >= 0 && k + 2 < lg_n)
            chk(lg_addr[k+1] == b_addr && lg_addr[k+2] == b_addr, "R5", "reads to last address",
                lg_addr[k+2], b_addr);
    endtask

    task automatic t_busy_writes();
        int k;
        int nxt;
        bit took;
        logic [ADDR_W-1:0] cur;
        cur = mk(1, 100, 0);
        bank_open = '0;
        do_reset();
        for (int i = 0; i < 70; i++) begin
            usr_valid = 1'b1; usr_is_read = 1'b0; usr_addr = cur;
            @(negedge clk);
            took = usr_ready;
            @(posedge clk); #1;
            if (took) cur = cur + 1;
        end
        usr_valid = 1'b0;
        repeat (2) @(posedge clk);
        k = first_tagged();
        chk(k > 0, "R3", "injection during write stream", k, 1);
        if (k > 0 && k + 3 < lg_n) begin
            nxt = k + 3;
            chk(lg_addr[k+1] == lg_addr[nxt] && lg_tag[nxt] == 1'b0, "R4", "target is queue head",
                lg_addr[k+1], lg_addr[nxt]);
            chk(lg_addr[k+1] != lg_addr[k-1], "R4", "target differs from last write",
                lg_addr[k+1], lg_addr[nxt]);
            chk(lg_cyc[k+2] - lg_cyc[k] == 2 && lg_tag[k+1], "R7", "no user command inside injection",
                lg_cyc[k+2] - lg_cyc[k], 2);
            chk(lg_op[k] == 2'd2 && lg_tag[k], "R8", "injected activate tagged", lg_op[k], 2);
        end
    endtask

    task automatic t_user_pairs();
        int k;
        bank_open = '0;
        do_reset();
        for (int p = 0; p < 7; p++) begin
            repeat (3) @(posedge clk); #1;
            usr_valid = 1'b1; usr_is_read = 1'b1; usr_addr = mk(3, p, 0);
            @(posedge clk); #1;
            usr_addr = mk(3, p, 1);
            @(posedge clk); #1;
            usr_valid = 1'b0;
            repeat (25) @(posedge clk);
        end
        k = first_tagged();
        chk(k == -1, "R2", "no injection with user pairs", k, -1);
        chk(lg_n == 14, "R2", "all user reads forwarded", lg_n, 14);
    endtask

    task automatic t_single_reads();
        int k;
        bit took;
        bank_open = '0;
        do_reset();
        for (int p = 0; p < 12; p++) begin
            usr_valid = 1'b1; usr_is_read = 1'b1; usr_addr = mk(0, 3, p);
            took = 1'b0;
            while (!took) begin
                @(negedge clk);
                took = usr_ready;
                @(posedge clk); #1;
            end
            usr_valid = 1'b0;
            repeat (8) @(posedge clk); #1;
        end
        k = first_tagged();
        chk(k >= 0, "R2", "single reads do not satisfy interval", k, 0);
    endtask

    task automatic t_stall();
        int rd [0:7];
        int n;
        bit found;
        bank_open = '0;
        do_reset();
        stall_arm = 1'b1;
        repeat (100) @(posedge clk);
        n = 0;
        for (int i = 0; i < lg_n; i++)
            if (lg_tag[i] && lg_op[i] == 2'd0 && n < 8) begin rd[n] = lg_cyc[i]; n++; end
        chk(n >= 4, "R10", "injection repeated after split pair", n, 4);
        if (n >= 4) begin
            chk(rd[1] - rd[0] == 2, "R10", "first pair split by stall", rd[1] - rd[0], 2);
            found = (rd[3] - rd[2] == 1);
            chk(found, "R10", "retry pair back-to-back", rd[3] - rd[2], 1);
        end
    endtask

    task automatic t_ret_filter();
        logic       vs [0:3] = '{1'b1, 1'b1, 1'b1, 1'b0};
        logic       ts [0:3] = '{1'b0, 1'b1, 1'b0, 1'b0};
        logic [DW-1:0] ds [0:3] = '{16'h1111, 16'h2222, 16'h3333, 16'h0000};
        do_reset();
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            if (i >= 1) begin
                chk(usr_rd_valid == (vs[i-1] && !ts[i-1]), "R9", "user valid per beat",
                    usr_rd_valid, vs[i-1] && !ts[i-1]);
                if (vs[i-1] && !ts[i-1])
                    chk(usr_rd_data == ds[i-1], "R9", "user data order", usr_rd_data, ds[i-1]);
            end
            if (i < 4) begin
                ret_valid = vs[i]; ret_tag = ts[i]; ret_data = ds[i];
            end else begin
                ret_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL all watchdog expired: actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_idle_closed();
        t_idle_open();
        t_last_addr();
        t_busy_writes();
        t_user_pairs();
        t_single_reads();
        t_stall();
        t_ret_filter();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule